// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the target-side protocol engine of a 256-byte memory that sits on a two-wire serial bus. It samples the bus clock and data lines with the system clock and finds start and stop conditions. It checks the device address byte against a fixed type code and three strap inputs, and it acknowledges by pulling the data line low through an open-drain output enable. It carries out byte and page writes and current-address, random and sequential reads.

Each written byte goes to an external write engine as a one-cycle pulse that carries the target address. A commit pulse follows at the stop condition. Read bytes come from an external synchronous storage array with one cycle of read latency. A word-address counter is kept between transactions. It wraps across the whole array during reads and within an 8-byte page during writes. While the write engine reports busy, the block does not acknowledge its device address, so the master can poll for the end of the write.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe_o` = 0) and the word-address counter is zero, so a first current-address read returns the byte at address 0x00.
- R2: The device address byte, sent MSB first, is accepted only when bits 7..4 are 1010 and bits 3..1 equal `strap_i`. Bit 0 = 1 selects read and 0 selects write. On a mismatch the byte is not acknowledged, no write or read request is issued, the counter is unchanged, and the block waits for the next start.
- R3: Every accepted byte is acknowledged by holding the data line low for the whole ninth clock. Bytes move MSB first in both directions.
- R4: A start (data falls while the clock is high) or a stop (data rises while the clock is high) is recognised in any state, even in the middle of a byte. The output is released and a start begins a new device address byte.
- R5: In a write, the first byte after the device address loads the word-address counter. Each later byte produces one `wr_valid_o` pulse with `wr_addr_o` equal to the counter and `wr_data_o` equal to the byte. A stop that ends a write containing at least one data byte produces one `wr_commit_o` pulse.
- R6: After each written byte, only the low 3 counter bits increment, wrapping within the 8-byte page. A 10-byte write starting at 0x3E lands at 0x3E, 0x3F, 0x38 .. 0x3F.
- R7: A read without a word-address phase returns the byte at the counter. The counter always holds the last accessed address plus one, using the wrap rule of that access.
- R8: A random read (write-mode address phase, repeated start, read-mode device address) returns the byte at the newly loaded address.
- R9: During a read, a master acknowledge moves on to the next address, wrapping from 0xFF to 0x00. A master non-acknowledge ends the data output, and the line stays released.
- R10: While `busy_i` is high the device address is not acknowledged. Polling succeeds once `busy_i` has fallen.
- R11: `sda_oe_o` changes only in the system clock after a detected falling bus clock edge, or after a start or stop. The data line is therefore stable while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Hard-wired device select bits |
| busy_i | input | 1 | Write engine busy with an internal write |
| wr_valid_o | output | 1 | One-cycle pulse: a data byte to write |
| wr_addr_o | output | AW | Address of the byte to write |
| wr_data_o | output | 8 | Byte to write |
| wr_commit_o | output | 1 | One-cycle pulse at the stop that ends a write |
| rd_en_o | output | 1 | Read request to the storage array |
| rd_addr_o | output | AW | Read address |
| rd_data_i | input | 8 | Read data, valid one cycle after `rd_en_o` |

## Verification
A bus clock edge at the pad reaches the engine after two synchroniser flops, so an edge is seen about two system clocks late. An acknowledge or data bit then appears on `sda_oe_o` about four clocks after the falling edge (synchroniser, edge register, output register). A written byte shows on `wr_valid_o` about three clocks after the eighth rising edge. The bench holds each bus clock phase for ten or more system clocks and samples the line a full quarter-bit after the rising edge, and again just before the falling edge, so every sample lands well after the value has settled. The busy, polling and counter results are read back only at later bus transactions.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    localparam int BYTE_W   = 8;
    localparam int BIT_W    = $clog2(BYTE_W);
    localparam int STRAP_W  = 3;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
    localparam logic [3:0]       DEV_TYPE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_PREP,
        ST_ACK_HOLD,
        ST_TX,
        ST_TX_END,
        ST_MACK,
        ST_MACK_END
    } st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_WORD,
        PH_DATA
    } ph_e;

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic rise_o,
    output logic fall_dly_o,
    output logic start_o,
    output logic stop_o
);

    localparam int LINES = 2;

    logic [LINES-1:0] pins;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev_q;
    logic             fall_dly_q;
    logic             fall;

    assign pins = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] sh_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q <= '1;
            end else begin
                sh_q <= {sh_q[STAGES-2:0], pins[g]};
            end
        end
        assign synced[g] = sh_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q     <= '1;
            fall_dly_q <= 1'b0;
        end else begin
            prev_q     <= synced;
            fall_dly_q <= fall;
        end
    end

    assign scl_o      = synced[1];
    assign sda_o      = synced[0];
    assign rise_o     = synced[1] & ~prev_q[1];
    assign fall       = ~synced[1] & prev_q[1];
    assign fall_dly_o = fall_dly_q;
    assign start_o    = synced[1] & prev_q[1] & prev_q[0] & ~synced[0];
    assign stop_o     = synced[1] & prev_q[1] & ~prev_q[0] & synced[0];

endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
    parameter int AW        = 8,
    parameter int PAGE_BITS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_val_i,
    input  logic          step_rd_i,
    input  logic          step_wr_i,
    output logic [AW-1:0] addr_o
);

    localparam logic [AW-1:0]        ONE_A = AW'(1);
    localparam logic [PAGE_BITS-1:0] ONE_P = PAGE_BITS'(1);

    logic [AW-1:0] ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load_i) begin
            ctr_d = load_val_i;
        end else if (step_rd_i) begin
            ctr_d = ctr_q + ONE_A;
        end else if (step_wr_i) begin
            ctr_d = {ctr_q[AW-1:PAGE_BITS], ctr_q[PAGE_BITS-1:0] + ONE_P};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign addr_o = ctr_q;

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int AW          = 8,
    parameter int PAGE_BITS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    output logic               wr_valid_o,
    output logic [AW-1:0]      wr_addr_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic               wr_commit_o,
    output logic               rd_en_o,
    output logic [AW-1:0]      rd_addr_o,
    input  logic [BYTE_W-1:0]  rd_data_i
);

    typedef struct packed {
        st_e               st;
        ph_e               ph;
        logic              rd;
        logic [BIT_W-1:0]  bits;
        logic [BYTE_W-1:0] sr;
        logic              ack;
        logic              oe;
        logic              wrote;
        logic              wr_v;
        logic [AW-1:0]     wr_a;
        logic [BYTE_W-1:0] wr_d;
        logic              commit;
        logic              rd_pend;
    } state_t;

    state_t q, n;

    logic              scl_s, sda_s, rise, fall_dly, start_det, stop_det;
    logic [AW-1:0]     ctr_addr;
    logic              ctr_load, ctr_rd, ctr_wr, rd_req;
    logic [AW-1:0]     ctr_val;
    logic [BYTE_W-1:0] byte_in;
    logic              dev_ok;

    twi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .rise_o     (rise),
        .fall_dly_o (fall_dly),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    twi_addr_ctr #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i (ctr_val),
        .step_rd_i  (ctr_rd),
        .step_wr_i  (ctr_wr),
        .addr_o     (ctr_addr)
    );

    assign byte_in = {q.sr[BYTE_W-2:0], sda_s};
    assign dev_ok  = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:1] == strap_i) && !busy_i;
    assign ctr_val = byte_in[AW-1:0];

    always_comb begin
        n          = q;
        n.wr_v     = 1'b0;
        n.commit   = 1'b0;
        n.rd_pend  = 1'b0;
        ctr_load   = 1'b0;
        ctr_rd     = 1'b0;
        ctr_wr     = 1'b0;
        rd_req     = 1'b0;

        if (q.rd_pend) begin
            n.sr = rd_data_i;
        end

        if (start_det) begin
            n.st    = ST_RX;
            n.ph    = PH_DEV;
            n.bits  = '0;
            n.oe    = 1'b0;
            n.wrote = 1'b0;
        end else if (stop_det) begin
            n.st     = ST_IDLE;
            n.oe     = 1'b0;
            n.commit = q.wrote;
            n.wrote  = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (rise) begin
                        n.sr   = byte_in;
                        n.bits = q.bits + BIT_W'(1);
                        if (q.bits == LAST_BIT) begin
                            n.st  = ST_ACK_PREP;
                            n.ack = 1'b1;
                            case (q.ph)
                                PH_DEV: begin
                                    n.ack = dev_ok;
                                    n.rd  = byte_in[0];
                                    if (dev_ok && byte_in[0]) begin
                                        rd_req    = 1'b1;
                                        ctr_rd    = 1'b1;
                                        n.rd_pend = 1'b1;
                                    end
                                end
                                PH_WORD: begin
                                    ctr_load = 1'b1;
                                end
                                default: begin
                                    n.wr_v  = 1'b1;
                                    n.wr_a  = ctr_addr;
                                    n.wr_d  = byte_in;
                                    n.wrote = 1'b1;
                                    ctr_wr  = 1'b1;
                                end
                            endcase
                        end
                    end
                end
                ST_ACK_PREP: begin
                    if (fall_dly) begin
                        if (q.ack) begin
                            n.oe = 1'b1;
                            n.st = ST_ACK_HOLD;
                        end else begin
                            n.oe = 1'b0;
                            n.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK_HOLD: begin
                    if (fall_dly) begin
                        n.bits = '0;
                        if (q.rd) begin
                            n.st = ST_TX;
                            n.oe = ~q.sr[BYTE_W-1];
                        end else begin
                            n.oe = 1'b0;
                            n.st = ST_RX;
                            n.ph = (q.ph == PH_DEV) ? PH_WORD : PH_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (rise) begin
                        n.bits = q.bits + BIT_W'(1);
                        if (q.bits == LAST_BIT) begin
                            n.st = ST_TX_END;
                        end
                    end else if (fall_dly) begin
                        n.sr = {q.sr[BYTE_W-2:0], 1'b0};
                        n.oe = ~q.sr[BYTE_W-2];
                    end
                end
                ST_TX_END: begin
                    if (fall_dly) begin
                        n.oe = 1'b0;
                        n.st = ST_MACK;
                    end
                end
                ST_MACK: begin
                    if (rise) begin
                        if (!sda_s) begin
                            rd_req    = 1'b1;
                            ctr_rd    = 1'b1;
                            n.rd_pend = 1'b1;
                            n.st      = ST_MACK_END;
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                end
                ST_MACK_END: begin
                    if (fall_dly) begin
                        n.st   = ST_TX;
                        n.bits = '0;
                        n.oe   = ~q.sr[BYTE_W-1];
                    end
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o    = q.oe;
    assign wr_valid_o  = q.wr_v;
    assign wr_addr_o   = q.wr_a;
    assign wr_data_o   = q.wr_d;
    assign wr_commit_o = q.commit;
    assign rd_en_o     = rd_req;
    assign rd_addr_o   = ctr_addr;

endmodule

// File: rtl/twi_mem_chk.sv
module twi_mem_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_oe_o,
    input logic fall_dly,
    input logic start_det,
    input logic stop_det,
    input logic wr_valid_o,
    input logic rd_en_o,
    input logic wr_commit_o
);

    // R11
    oe_rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(fall_dly));

    // R11
    oe_fall_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe_o) |-> $past(fall_dly || start_det || stop_det));

    // R4
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe_o);

    // R4
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe_o);

    // R5
    commit_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit_o |-> $past(stop_det));

    // R5
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid_o, rd_en_o}));

endmodule

bind twi_mem_slave twi_mem_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sda_oe_o    (sda_oe_o),
    .fall_dly    (fall_dly),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .wr_valid_o  (wr_valid_o),
    .rd_en_o     (rd_en_o),
    .wr_commit_o (wr_commit_o)
);

// File: tb/sim_twi_mem_slave.sv
`timescale 1ns/1ps
module sim_twi_mem_slave;

    localparam int Q      = 10;
    localparam int BUSY_T = 3000;
    localparam logic [7:0] DEV_W = 8'hAA;
    localparam logic [7:0] DEV_R = 8'hAB;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic       busy;
    logic       wr_valid, wr_commit, rd_en;
    logic [7:0] wr_addr, wr_data, rd_addr;
    logic [7:0] rd_data;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] rbuf [16];
    logic [7:0] last_wa, last_wd;
    int         busy_cnt = 0;
    int         wr_cnt = 0, rd_cnt = 0, commit_cnt = 0;
    int         r11_bad = 0;
    int         n_chk = 0, n_err = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign busy     = (busy_cnt != 0);

    twi_mem_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .strap_i     (3'b101),
        .busy_i      (busy),
        .wr_valid_o  (wr_valid),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .wr_commit_o (wr_commit),
        .rd_en_o     (rd_en),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data)
    );

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'(i * 3 + 7);
            exp_mem[i] = 8'(i * 3 + 7);
        end
    end

    always @(posedge clk) begin
        if (wr_valid) begin
            mem[wr_addr] <= wr_data;
            last_wa      <= wr_addr;
            last_wd      <= wr_data;
            wr_cnt       <= wr_cnt + 1;
        end
        if (rd_en) begin
            rd_data <= mem[rd_addr];
            rd_cnt  <= rd_cnt + 1;
        end
        if (wr_commit) begin
            commit_cnt <= commit_cnt + 1;
            busy_cnt   <= BUSY_T;
        end else if (busy_cnt != 0) begin
            busy_cnt <= busy_cnt - 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        logic s1;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        s1 = sda_line;
        tick(Q - 1);
        b = sda_line;
        if (s1 !== b) r11_bad++;
        tick(1);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!mack);
    endtask

    task automatic read_run(input int cnt);
        for (int i = 0; i < cnt; i++) recv_byte(rbuf[i], i != cnt - 1);
        bus_stop();
    endtask

    task automatic wait_ready(output int polls);
        logic ack;
        polls = 0;
        do begin
            bus_start();
            send_byte(DEV_W, ack);
            bus_stop();
            polls++;
        end while (!ack && polls < 40);
    endtask

    task automatic t_reset();
        tick(3);
        check(sda_oe == 1'b0, "R1 line released after reset", int'(sda_oe), 0);
        check(wr_valid == 1'b0 && rd_en == 1'b0, "R1 no requests after reset",
              int'({wr_valid, rd_en}), 0);
    endtask

    task automatic t_first_current();
        logic ack;
        bus_start();
        send_byte(DEV_R, ack);
        check(ack, "R3 ack of read device address", int'(ack), 1);
        read_run(1);
        check(rbuf[0] == exp_mem[0], "R1 R7 first current read at 00", rbuf[0], exp_mem[0]);
    endtask

    task automatic t_mismatch();
        logic ack;
        int   w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        bus_start();
        send_byte(8'hA2, ack);
        check(!ack, "R2 wrong strap not acked", int'(ack), 0);
        send_byte(8'h20, ack);
        send_byte(8'h55, ack);
        bus_stop();
        bus_start();
        send_byte(8'hBA, ack);
        check(!ack, "R2 wrong type code not acked", int'(ack), 0);
        bus_stop();
        tick(4);
        check(wr_cnt == w0 && rd_cnt == r0, "R2 no request on mismatch", wr_cnt + rd_cnt, w0 + r0);
        bus_start();
        send_byte(DEV_R, ack);
        read_run(1);
        check(rbuf[0] == exp_mem[1], "R2 R7 counter unchanged by mismatch", rbuf[0], exp_mem[1]);
    endtask

    task automatic t_byte_write();
        logic ack, a1, a2, a3;
        int   c0, polls;
        c0 = commit_cnt;
        bus_start();
        send_byte(DEV_W, a1);
        send_byte(8'h10, a2);
        send_byte(8'hA5, a3);
        check(a1 && a2 && a3, "R3 all write bytes acked", int'({a1, a2, a3}), 7);
        bus_stop();
        exp_mem[8'h10] = 8'hA5;
        tick(2);
        check(last_wa == 8'h10 && last_wd == 8'hA5, "R5 write request address and data",
              {last_wa, last_wd}, 16'h10A5);
        check(commit_cnt == c0 + 1, "R5 one commit at stop", commit_cnt, c0 + 1);
        bus_start();
        send_byte(DEV_W, ack);
        bus_stop();
        check(!ack, "R10 device address refused while busy", int'(ack), 0);
        wait_ready(polls);
        check(polls > 1 && polls < 40, "R10 poll acked after busy ends", polls, 2);
        check(commit_cnt == c0 + 1, "R5 no commit without data bytes", commit_cnt, c0 + 1);
    endtask

    task automatic t_random_read(input logic [7:0] a, input int cnt, input string tag);
        logic ack1, ack2, ack3;
        bus_start();
        send_byte(DEV_W, ack1);
        send_byte(a, ack2);
        bus_start();
        send_byte(DEV_R, ack3);
        read_run(cnt);
        for (int i = 0; i < cnt; i++) begin
            check(ack1 && ack2 && ack3 && rbuf[i] == exp_mem[8'(a + i)], tag,
                  rbuf[i], exp_mem[8'(a + i)]);
        end
    endtask

    task automatic t_current(input logic [7:0] a, input string tag);
        logic ack;
        bus_start();
        send_byte(DEV_R, ack);
        read_run(1);
        check(ack && rbuf[0] == exp_mem[a], tag, rbuf[0], exp_mem[a]);
    endtask

    task automatic t_page_write();
        logic       ack;
        int         polls, w0;
        logic [7:0] base = 8'h3E;
        w0 = wr_cnt;
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(base, ack);
        for (int i = 0; i < 10; i++) begin
            send_byte(8'(8'hD0 + i), ack);
            exp_mem[{base[7:3], 3'(base[2:0] + i)}] = 8'(8'hD0 + i);
        end
        bus_stop();
        check(wr_cnt == w0 + 10, "R5 ten write requests", wr_cnt, w0 + 10);
        check(last_wa == 8'h3F, "R6 last byte wrapped within page", last_wa, 8'h3F);
        wait_ready(polls);
        t_current(8'h38, "R6 R7 counter wrapped to page start");
        t_random_read(8'h38, 8, "R6 page contents after wrap");
        t_current(8'h40, "R7 counter after sequential read");
    endtask

    task automatic t_wrap_read();
        t_random_read(8'hFE, 3, "R9 sequential read wraps FF to 00");
        tick(2);
        check(sda_oe == 1'b0, "R9 line released after master nack", int'(sda_oe), 0);
        t_current(8'h01, "R9 R7 counter after full wrap");
    endtask

    task automatic t_start_any();
        logic ack;
        int   w0;
        w0 = wr_cnt;
        bus_start();
        send_byte(DEV_W, ack);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        send_byte(DEV_R, ack);
        check(ack, "R4 repeated start mid byte restarts address", int'(ack), 1);
        read_run(1);
        check(rbuf[0] == exp_mem[2], "R4 mid byte start left counter alone", rbuf[0], exp_mem[2]);
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h50, ack);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_stop();
        tick(4);
        check(sda_oe == 1'b0 && wr_cnt == w0, "R4 stop mid byte drops partial byte",
              wr_cnt, w0);
        t_current(8'h50, "R4 R7 word address kept after abort");
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        t_reset();
        t_first_current();
        t_mismatch();
        t_byte_write();
        t_random_read(8'h10, 1, "R8 random read returns written byte");
        t_current(8'h11, "R7 current read follows random read");
        t_page_write();
        t_wrap_read();
        t_start_any();
        check(r11_bad == 0, "R11 line stable during clock high", r11_bad, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule